// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A per-core monitoring block that software programs through a simple word-addressed register port. It holds a 64-bit cycle counter and six 32-bit event counters. Each event counter has a type register whose select field names one of the event strobes on `evt_in`. A strobe might mark a cache access, a cache refill, a TLB refill or a bus transfer. Software starts the counters with one global enable bit. It can preload any counter with a start value, so the counter overflows after a chosen number of events. An overflow latches a sticky status bit, and that bit can raise an interrupt.

An odd-numbered event counter can be chained to the even counter below it. It then advances once per overflow of that counter, and the pair holds a 64-bit count. The cycle counter signals overflow either when its low word wraps or when all 64 bits wrap, as a control bit selects. Every access carries a privilege flag. Unprivileged accesses succeed only while a user-access register is set, and that register can only be written with privilege.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every counter, the enable, the width mode, overflow status, interrupt enables, chain bits and user access are zero, and `irq` is low.
- R2: The control register is at address 0 and its bit 0 is the global enable. While it is set, the cycle counter (low word at address 1, high word at address 2) grows by one per clock. While it is clear the counter holds its value.
- R3: Event counter i sits at address 8+2i and its type register at 9+2i, with the select in bits 7:0. While enabled, counter i grows by one on each clock where `evt_in[select]` is high. A select of 8 or more never counts, and a disabled unit counts nothing.
- R4: Writing 1 to control bit 1 clears all event counters, and writing 1 to control bit 2 clears the cycle counter. Both bits read back as 0. Control bits 15:11 always read the number of event counters (6).
- R5: A write stores any start value into a counter. When a write and an increment hit the same counter in the same cycle, the written value wins.
- R6: When a counter wraps from all-ones, its status bit is set at address 3 (bit i for event counter i, bit 31 for the cycle counter). The bit stays set until software writes 1 to it. A new overflow in the same cycle as the clear leaves the bit set.
- R7: `irq` is high exactly when some status bit is set whose enable bit at address 4 (same bit positions) is also set.
- R8: Bit 8 of an odd counter's type register chains that counter to the counter below it. The chained counter then grows only when the lower counter overflows. On even counters bit 8 is ignored and reads 0.
- R9: Control bit 3 selects the cycle overflow point. At 0 the cycle status sets when the low 32 bits wrap. At 1 it sets only when all 64 bits wrap.
- R10: The user-access bit is bit 0 at address 5. An unprivileged access is accepted only while it is set, and never to address 5 itself. A rejected access reads 0, changes nothing, and raises `acc_err` for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_priv | input | 1 | Access comes from the privileged level |
| req_addr | input | 5 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational in the cycle of the read |
| acc_err | output | 1 | One-cycle pulse after a rejected access |
| evt_in | input | 8 | Event strobes, one per event source |
| irq | output | 1 | Overflow interrupt request |

## Verification
The checker assumes that `req_*` is stable across each clock edge. Its step checks for the cycle counter and for the sticky status bits apply only in cycles with no access, since a write may legally change those registers. The bench drives every input on the falling edge and samples on the falling edge, which keeps those assumptions. Counter outcomes are planned around edge counts: a write lands at one edge and the increments follow at the next edges. Each case therefore places enable, preload and strobe edges so that the expected total is known exactly.

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit #(
  parameter int NC = 6,
  parameter int NE = 8,
  parameter int AW = 5,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_priv,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rd_data,
  output logic          acc_err,
  input  logic [NE-1:0] evt_in,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_CYCL  = AW'(1);
  localparam logic [AW-1:0] A_CYCH  = AW'(2);
  localparam logic [AW-1:0] A_OVF   = AW'(3);
  localparam logic [AW-1:0] A_INTEN = AW'(4);
  localparam logic [AW-1:0] A_USER  = AW'(5);
  localparam int A_BASE = 8;

  logic          ctrl_en, ctrl_long, user_en, ovf_cyc, inten_cyc;
  logic [63:0]   cyc;
  logic [31:0]   cnt [NC];
  logic [SW-1:0] sel [NC];
  logic [NC-1:0] chn, ovf_ev, inten_ev, hit, cnt_wr, typ_wr, ev_inc, ev_ovf;
  logic [31:0]   rdv;

  wire allowed   = req_priv | (user_en & (req_addr != A_USER));
  wire wr        = req_valid & allowed & req_write;
  wire ctrl_wr   = wr & (req_addr == A_CTRL);
  wire rst_ev    = ctrl_wr & req_wdata[1];
  wire rst_cyc   = ctrl_wr & req_wdata[2];
  wire cyc_wr_lo = wr & (req_addr == A_CYCL);
  wire cyc_wr_hi = wr & (req_addr == A_CYCH);
  wire ovf_wr    = wr & (req_addr == A_OVF);
  wire cyc_inc   = ctrl_en & ~cyc_wr_lo & ~cyc_wr_hi & ~rst_cyc;
  wire cyc_ovf   = cyc_inc & (ctrl_long ? (&cyc) : (&cyc[31:0]));

  always_comb begin
    hit = '0;
    for (int i = 0; i < NC; i++)
      for (int e = 0; e < NE; e++)
        if (sel[i] == SW'(e)) hit[i] = evt_in[e];
  end

  for (genvar gi = 0; gi < NC; gi++) begin : g_cnt
    assign cnt_wr[gi] = wr & (req_addr == AW'(A_BASE + 2*gi));
    assign typ_wr[gi] = wr & (req_addr == AW'(A_BASE + 2*gi + 1));
    if (gi % 2 == 1) begin : g_odd
      wire carry = ctrl_en & hit[gi-1] & (&cnt[gi-1]) & ~cnt_wr[gi-1] & ~rst_ev;
      assign ev_inc[gi] = chn[gi] ? carry : (ctrl_en & hit[gi]);
    end else begin : g_even
      assign ev_inc[gi] = ctrl_en & hit[gi];
    end
    assign ev_ovf[gi] = ev_inc[gi] & (&cnt[gi]) & ~cnt_wr[gi] & ~rst_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        cnt[i] <= '0;
        sel[i] <= '0;
      end
      chn <= '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (rst_ev)         cnt[i] <= '0;
        else if (cnt_wr[i]) cnt[i] <= req_wdata;
        else if (ev_inc[i]) cnt[i] <= cnt[i] + 32'd1;
        if (typ_wr[i]) begin
          sel[i] <= req_wdata[SW-1:0];
          chn[i] <= (i % 2 == 1) & req_wdata[SW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
    end else if (rst_cyc) begin
      cyc <= '0;
    end else begin
      if (cyc_wr_lo) cyc[31:0]  <= req_wdata;
      if (cyc_wr_hi) cyc[63:32] <= req_wdata;
      if (cyc_inc)   cyc        <= cyc + 64'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_long <= 1'b0;
      user_en   <= 1'b0;
      ovf_ev    <= '0;
      ovf_cyc   <= 1'b0;
      inten_ev  <= '0;
      inten_cyc <= 1'b0;
      acc_err   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_en   <= req_wdata[0];
        ctrl_long <= req_wdata[3];
      end
      if (wr && req_addr == A_USER) user_en <= req_wdata[0];
      if (wr && req_addr == A_INTEN) begin
        inten_ev  <= req_wdata[NC-1:0];
        inten_cyc <= req_wdata[31];
      end
      ovf_ev  <= (ovf_ev & ~(ovf_wr ? req_wdata[NC-1:0] : '0)) | ev_ovf;
      ovf_cyc <= (ovf_cyc & ~(ovf_wr & req_wdata[31])) | cyc_ovf;
      acc_err <= req_valid & ~allowed;
    end
  end

  always_comb begin
    rdv = '0;
    case (req_addr)
      A_CTRL: begin
        rdv[0]     = ctrl_en;
        rdv[3]     = ctrl_long;
        rdv[15:11] = 5'(NC);
      end
      A_CYCL:  rdv = cyc[31:0];
      A_CYCH:  rdv = cyc[63:32];
      A_OVF: begin
        rdv[NC-1:0] = ovf_ev;
        rdv[31]     = ovf_cyc;
      end
      A_INTEN: begin
        rdv[NC-1:0] = inten_ev;
        rdv[31]     = inten_cyc;
      end
      A_USER:  rdv[0] = user_en;
      default: begin
        for (int i = 0; i < NC; i++) begin
          if (req_addr == AW'(A_BASE + 2*i)) rdv = cnt[i];
          if (req_addr == AW'(A_BASE + 2*i + 1)) begin
            rdv[SW-1:0] = sel[i];
            rdv[SW]     = chn[i];
          end
        end
      end
    endcase
  end

  assign rd_data = (req_valid & ~req_write & allowed) ? rdv : '0;
  assign irq     = (|(ovf_ev & inten_ev)) | (ovf_cyc & inten_cyc);
endmodule

module pmu_counter_unit_chk #(
  parameter int NC = 6,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_priv,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   rd_data,
  input logic          acc_err,
  input logic          irq,
  input logic          en,
  input logic          user_en,
  input logic [63:0]   cyc,
  input logic [NC-1:0] ovf_ev,
  input logic          ovf_cyc
);
  p_reject_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_priv && !user_en) |-> rd_data == 32'd0);

  p_reject_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && !user_en) |=> acc_err);

  p_priv_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_priv) |=> !acc_err);

  p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !req_valid) |=> cyc == $past(cyc) + 64'd1);

  p_cycle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req_valid) |=> $stable(cyc));

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (($past(ovf_ev) & ~ovf_ev) == '0) && !($past(ovf_cyc) && !ovf_cyc));

  p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_ev != '0) || ovf_cyc);

  p_strobes_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_priv && req_addr == AW'(0)) |-> rd_data[2:1] == 2'b00);
endmodule

bind pmu_counter_unit pmu_counter_unit_chk #(.NC(NC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_priv(req_priv), .req_addr(req_addr), .rd_data(rd_data), .acc_err(acc_err),
  .irq(irq), .en(ctrl_en), .user_en(user_en), .cyc(cyc), .ovf_ev(ovf_ev),
  .ovf_cyc(ovf_cyc)
);

// File: tb/pmu_counter_unit_tb.sv
module pmu_counter_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_priv = 0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        acc_err, irq;
  logic [7:0]  evt_in = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic        last_err;

  localparam logic [4:0] CTRL = 0, CYCL = 1, CYCH = 2, OVF = 3, INTEN = 4, USER = 5;
  function automatic logic [4:0] cnt_a(int i); return 5'(8 + 2*i); endfunction
  function automatic logic [4:0] typ_a(int i); return 5'(9 + 2*i); endfunction

  always #5 clk = ~clk;

  pmu_counter_unit u_dut (.*);

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic p = 1);
    req_valid = 1; req_write = 1; req_priv = p; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    last_err = acc_err;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d, input logic p = 1);
    req_valid = 1; req_write = 0; req_priv = p; req_addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    last_err = acc_err;
    req_valid = 0;
  endtask

  task automatic pulse(logic [7:0] m, int n);
    for (int k = 0; k < n; k++) begin
      evt_in = m; @(negedge clk);
    end
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTRL, v);   check("R1 ctrl", v, 32'h0000_3000);
    rd(CYCL, v);   check("R1 cycle low", v, 0);
    rd(OVF, v);    check("R1 status", v, 0);
    rd(USER, v);   check("R1 user", v, 0);
    rd(cnt_a(0), v); check("R1 counter0", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_cycle;
    logic [31:0] a, b;
    wr(CYCL, 10); wr(CYCH, 0);
    wr(CTRL, 1); repeat (3) @(negedge clk); wr(CTRL, 0);
    rd(CYCL, a); check("R2 cycles counted", a, 14);
    rd(CYCH, a); check("R2 cycle high", a, 0);
    rd(CYCL, a); rd(CYCL, b); check("R2 disabled holds", b - a, 0);
    wr(CTRL, 1); rd(CYCL, a); rd(CYCL, b); wr(CTRL, 0);
    check("R2 enabled steps by one", b - a, 1);
  endtask

  task automatic t_events;
    logic [31:0] v;
    wr(typ_a(0), 2); wr(typ_a(1), 7); wr(typ_a(2), 9);
    wr(CTRL, 1);
    pulse(8'h04, 5); pulse(8'h84, 3); pulse(8'hFF, 2);
    wr(CTRL, 0);
    pulse(8'hFF, 4);
    rd(cnt_a(0), v); check("R3 select 2 count", v, 10);
    rd(cnt_a(1), v); check("R3 select 7 count", v, 5);
    rd(cnt_a(2), v); check("R3 out-of-range select", v, 0);
  endtask

  task automatic t_resets;
    logic [31:0] a, b;
    rd(CYCL, a);
    wr(CTRL, 2);
    rd(cnt_a(0), b); check("R4 event reset", b, 0);
    rd(cnt_a(1), b); check("R4 event reset c1", b, 0);
    rd(CYCL, b); check("R4 cycle untouched by event reset", b, a);
    wr(CTRL, 4);
    rd(CYCL, b); check("R4 cycle reset", b, 0);
    wr(CTRL, 32'h7);
    rd(CTRL, b); check("R4 strobes read 0", b, 32'h0000_3001);
    wr(CTRL, 0);
  endtask

  task automatic t_write_wins;
    logic [31:0] v;
    wr(typ_a(0), 0);
    evt_in = 8'h01;
    wr(CTRL, 1);
    wr(cnt_a(0), 100);
    rd(cnt_a(0), v); check("R5 write beats increment", v, 100);
    rd(cnt_a(0), v); check("R5 counting resumes", v, 101);
    evt_in = 0;
    wr(CTRL, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(CTRL, 2); wr(OVF, 32'hFFFF_FFFF);
    wr(typ_a(3), 1); wr(cnt_a(3), 32'hFFFF_FFFE);
    wr(CTRL, 1); pulse(8'h02, 2); wr(CTRL, 0);
    rd(cnt_a(3), v); check("R6 counter wrapped", v, 0);
    rd(OVF, v); check("R6 status bit 3", v, 32'h8);
    check("R7 irq masked", irq, 0);
    wr(INTEN, 8); check("R7 irq raised", irq, 1);
    wr(OVF, 8); check("R7 irq cleared", irq, 0);
    rd(OVF, v); check("R6 write-1 clear", v, 0);
    evt_in = 8'h02;
    wr(CTRL, 1); wr(cnt_a(3), 32'hFFFF_FFFF); wr(OVF, 8);
    evt_in = 0;
    wr(CTRL, 0);
    rd(OVF, v); check("R6 set beats clear", v, 32'h8);
    check("R7 irq after set", irq, 1);
    wr(OVF, 32'hFFFF_FFFF); wr(INTEN, 0);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    wr(typ_a(4), 32'h100);
    rd(typ_a(4), v); check("R8 chain ignored on even", v, 0);
    wr(typ_a(5), 32'h100);
    rd(typ_a(5), v); check("R8 chain bit on odd", v, 32'h100);
    wr(cnt_a(4), 32'hFFFF_FFFF); wr(cnt_a(5), 7);
    wr(CTRL, 1); pulse(8'h01, 1); wr(CTRL, 0);
    rd(cnt_a(4), v); check("R8 lower wrapped", v, 0);
    rd(cnt_a(5), v); check("R8 upper carried once", v, 8);
    rd(OVF, v); check("R8 lower status", v, 32'h10);
    wr(OVF, 32'hFFFF_FFFF);
  endtask

  task automatic t_cycmode;
    logic [31:0] v;
    wr(CYCL, 32'hFFFF_FFFF); wr(CYCH, 0);
    wr(CTRL, 1); wr(CTRL, 0);
    rd(CYCH, v); check("R9 low wrap carries", v, 1);
    rd(OVF, v); check("R9 32-bit mode flags", v, 32'h8000_0000);
    wr(OVF, 32'h8000_0000);
    wr(CYCL, 32'hFFFF_FFFF); wr(CYCH, 0);
    wr(CTRL, 9); wr(CTRL, 8);
    rd(CTRL, v); check("R9 mode bit reads", v, 32'h0000_3008);
    rd(OVF, v); check("R9 64-bit mode no flag", v, 0);
    wr(CYCL, 32'hFFFF_FFFF); wr(CYCH, 32'hFFFF_FFFF);
    wr(CTRL, 9); wr(CTRL, 8);
    rd(CYCH, v); check("R9 full wrap", v, 0);
    rd(OVF, v); check("R9 64-bit mode flags", v, 32'h8000_0000);
    wr(OVF, 32'hFFFF_FFFF); wr(CTRL, 0);
  endtask

  task automatic t_access;
    logic [31:0] v;
    wr(cnt_a(0), 32'h55);
    rd(cnt_a(0), v, 0); check("R10 rejected read zero", v, 0);
    check("R10 error pulse on read", last_err, 1);
    rd(cnt_a(0), v); check("R10 privileged read", v, 32'h55);
    check("R10 no error privileged", last_err, 0);
    wr(cnt_a(0), 32'h66, 0); check("R10 error pulse on write", last_err, 1);
    rd(cnt_a(0), v); check("R10 rejected write ignored", v, 32'h55);
    wr(USER, 1, 0);
    rd(USER, v); check("R10 user reg not self-set", v, 0);
    wr(USER, 1);
    rd(cnt_a(0), v, 0); check("R10 permitted read", v, 32'h55);
    check("R10 no error when permitted", last_err, 0);
    wr(cnt_a(0), 32'h66, 0);
    rd(cnt_a(0), v); check("R10 permitted write", v, 32'h66);
    wr(USER, 0, 0); check("R10 user reg guarded", last_err, 1);
    rd(cnt_a(0), v, 0); check("R10 still permitted", v, 32'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cycle;
    t_events;
    t_resets;
    t_write_wins;
    t_overflow;
    t_chain;
    t_cycmode;
    t_access;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule